// File: doc/BRIEF.md
# Pin-Level Fault Insertion Bank

This block is a row of per-pin switches that sits in series between a device under test and the socket it normally plugs into. Each switch passes its signal through untouched until a global fault enable is raised. A fault is applied only to the pins whose bit in a fault mask is set. Those pins are then corrupted in one of seven ways: forced high, forced low, forced to an externally supplied level, inverted, logically ANDed with the clean value of the next or the previous pin, or left floating.

Pins come in two groups. Unidirectional pins always carry a value from the device toward the socket. Bidirectional pins each have a direction input. Corruption is applied only along the direction in which the pin is currently carrying data. The undriven side sees the opposite raw value with its drive enable low.

Every pin also feeds a trace tap that carries the value as it was before any corruption. On a bidirectional pin this is taken from whichever side is driving. A recorder can use it to decide afterwards whether an injected fault actually changed anything. Pin count is set by two parameters, and the bank is meant for at most 96 pins in total. An open fault removes the drive enable, and the value shown on the floating line is a parameter that models a weak level.

Top module: `fi_pin_bank`

## Requirements
- R1: With fault_en low, every unidirectional pin gives uni_to_sock equal to uni_from_dev with uni_to_sock_drv high. Every bidirectional pin gives bd_to_sock equal to bd_from_dev and bd_to_dev equal to bd_from_sock, with the drive enables as in R12.
- R2: With fault_en high and the pin's mask bit set, fault code 0 forces the pin's active output to 1 and code 1 forces it to 0.
- R3: Code 2 forces the active output to the pin's bit of ext_level.
- R4: Code 3 drives the active output to the inverse of the pin's clean value.
- R5: Code 4 drives the active output to clean[i] AND clean[(i+1) mod N]. The pins are numbered with the unidirectional pins first (0..N_UNI-1), then the bidirectional pins.
- R6: Code 5 drives the active output to clean[i] AND clean[(i+N-1) mod N], using the same numbering as R5.
- R7: Code 6 (open) clears the active output's drive enable and shows the value OPEN_LEVEL on that output.
- R8: Code 7 is reserved and behaves as pass-through, exactly as in R1.
- R9: While a fault is active, pins whose mask bit is clear pass their clean value unchanged.
- R10: trace_tap[i] always equals the clean value of pin i, whatever the fault settings. For a bidirectional pin the clean value is bd_from_dev when its bd_dir bit is 1 (device toward socket) and bd_from_sock when it is 0.
- R11: On a bidirectional pin only the active direction is corrupted. With bd_dir=1, bd_to_dev equals bd_from_sock. With bd_dir=0, bd_to_sock equals bd_from_dev.
- R12: Outside an open fault, uni_to_sock_drv is 1, bd_to_sock_drv equals bd_dir, and bd_to_dev_drv equals the inverse of bd_dir. The inactive side's enable is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fault_en | input | 1 | Global fault activation |
| fault_kind | input | 3 | Fault code (0 high, 1 low, 2 external, 3 invert, 4 AND next, 5 AND previous, 6 open, 7 none) |
| fault_mask | input | N_UNI+N_BIDIR | Pins selected for corruption |
| ext_level | input | N_UNI+N_BIDIR | Per-pin level for code 2 |
| uni_from_dev | input | N_UNI | Device-side values of unidirectional pins |
| uni_to_sock | output | N_UNI | Socket-side values of unidirectional pins |
| uni_to_sock_drv | output | N_UNI | Socket-side drive enables of unidirectional pins |
| bd_dir | input | N_BIDIR | 1: device drives socket, 0: socket drives device |
| bd_from_dev | input | N_BIDIR | Device-side values of bidirectional pins |
| bd_from_sock | input | N_BIDIR | Socket-side values of bidirectional pins |
| bd_to_sock | output | N_BIDIR | Value presented toward the socket |
| bd_to_sock_drv | output | N_BIDIR | Drive enable toward the socket |
| bd_to_dev | output | N_BIDIR | Value presented toward the device |
| bd_to_dev_drv | output | N_BIDIR | Drive enable toward the device |
| trace_tap | output | N_UNI+N_BIDIR | Fault-free pin values |

## Verification
The bench builds the bank with five unidirectional and six bidirectional pins. This makes the bridging wrap at both ends and cross the boundary between the two pin groups. It also means both vector ends hold pins of different kinds. OPEN_LEVEL is set to 1 rather than the default 0, so a floating line is told apart from a stuck-low one. Random masks and direction vectors then cover every fault code on both groups with mixed flow directions.

// File: rtl/fi_pkg.sv
package fi_pkg;

  typedef enum logic [2:0] {
    FK_HIGH    = 3'd0,
    FK_LOW     = 3'd1,
    FK_EXT     = 3'd2,
    FK_FLIP    = 3'd3,
    FK_AND_UP  = 3'd4,
    FK_AND_DN  = 3'd5,
    FK_FLOAT   = 3'd6,
    FK_NONE    = 3'd7
  } fault_kind_e;

  typedef struct packed {
    logic val;
    logic drive;
  } pin_drv_t;

  // Corrupted value and drive enable of one pin for an active fault.
  function automatic pin_drv_t corrupt_bit(
    input logic [2:0] kind,
    input logic       clean,
    input logic       ext,
    input logic       up,
    input logic       dn,
    input logic       open_lvl
  );
    pin_drv_t r;
    r.val   = clean;
    r.drive = 1'b1;
    case (fault_kind_e'(kind))
      FK_HIGH:   r.val = 1'b1;
      FK_LOW:    r.val = 1'b0;
      FK_EXT:    r.val = ext;
      FK_FLIP:   r.val = ~clean;
      FK_AND_UP: r.val = clean & up;
      FK_AND_DN: r.val = clean & dn;
      FK_FLOAT: begin
        r.val   = open_lvl;
        r.drive = 1'b0;
      end
      default:   r.val = clean;
    endcase
    return r;
  endfunction

  // Wrapping neighbour indices along the full pin vector.
  function automatic int unsigned idx_up(input int unsigned i, input int unsigned n);
    return (i + 1) % n;
  endfunction

  function automatic int unsigned idx_dn(input int unsigned i, input int unsigned n);
    return (i + n - 1) % n;
  endfunction

endpackage

// File: rtl/fi_clean_sel.sv
module fi_clean_sel #(
  parameter int unsigned N_UNI   = 8,
  parameter int unsigned N_BIDIR = 8,
  localparam int unsigned N_PIN  = N_UNI + N_BIDIR
) (
  input  logic [N_UNI-1:0]   uni_from_dev,
  input  logic [N_BIDIR-1:0] bd_dir,
  input  logic [N_BIDIR-1:0] bd_from_dev,
  input  logic [N_BIDIR-1:0] bd_from_sock,
  output logic [N_PIN-1:0]   clean
);

  assign clean[N_UNI-1:0] = uni_from_dev;

  for (genvar j = 0; j < N_BIDIR; j++) begin : g_bd_clean
    assign clean[N_UNI+j] = bd_dir[j] ? bd_from_dev[j] : bd_from_sock[j];
  end

endmodule

// File: rtl/fi_elem.sv
module fi_elem
  import fi_pkg::*;
#(
  parameter logic OPEN_LEVEL = 1'b0
) (
  input  logic       hit,
  input  logic [2:0] kind,
  input  logic       clean,
  input  logic       ext,
  input  logic       up,
  input  logic       dn,
  output logic       out_val,
  output logic       out_drive
);

  pin_drv_t bad;

  always_comb begin
    bad = corrupt_bit(kind, clean, ext, up, dn, OPEN_LEVEL);
    if (hit) begin
      out_val   = bad.val;
      out_drive = bad.drive;
    end else begin
      out_val   = clean;
      out_drive = 1'b1;
    end
  end

endmodule

// File: rtl/fi_bidir_route.sv
module fi_bidir_route (
  input  logic dir,
  input  logic from_dev,
  input  logic from_sock,
  input  logic faulty_val,
  input  logic faulty_drive,
  output logic to_sock,
  output logic to_sock_drv,
  output logic to_dev,
  output logic to_dev_drv
);

  always_comb begin
    if (dir) begin
      to_sock     = faulty_val;
      to_sock_drv = faulty_drive;
      to_dev      = from_sock;
      to_dev_drv  = 1'b0;
    end else begin
      to_sock     = from_dev;
      to_sock_drv = 1'b0;
      to_dev      = faulty_val;
      to_dev_drv  = faulty_drive;
    end
  end

endmodule

// File: rtl/fi_pin_bank.sv
module fi_pin_bank
  import fi_pkg::*;
#(
  parameter int unsigned N_UNI      = 8,
  parameter int unsigned N_BIDIR    = 8,
  parameter logic        OPEN_LEVEL = 1'b0,
  localparam int unsigned N_PIN     = N_UNI + N_BIDIR
) (
  input  logic               fault_en,
  input  logic [2:0]         fault_kind,
  input  logic [N_PIN-1:0]   fault_mask,
  input  logic [N_PIN-1:0]   ext_level,
  input  logic [N_UNI-1:0]   uni_from_dev,
  output logic [N_UNI-1:0]   uni_to_sock,
  output logic [N_UNI-1:0]   uni_to_sock_drv,
  input  logic [N_BIDIR-1:0] bd_dir,
  input  logic [N_BIDIR-1:0] bd_from_dev,
  input  logic [N_BIDIR-1:0] bd_from_sock,
  output logic [N_BIDIR-1:0] bd_to_sock,
  output logic [N_BIDIR-1:0] bd_to_sock_drv,
  output logic [N_BIDIR-1:0] bd_to_dev,
  output logic [N_BIDIR-1:0] bd_to_dev_drv,
  output logic [N_PIN-1:0]   trace_tap
);

  // Named internal events
  logic [N_PIN-1:0] clean_vec;
  logic [N_PIN-1:0] hit_vec;
  logic [N_PIN-1:0] nb_up;
  logic [N_PIN-1:0] nb_dn;
  logic [N_PIN-1:0] faulty_val;
  logic [N_PIN-1:0] faulty_drive;

  fi_clean_sel #(.N_UNI(N_UNI), .N_BIDIR(N_BIDIR)) clean_i (
    .uni_from_dev (uni_from_dev),
    .bd_dir       (bd_dir),
    .bd_from_dev  (bd_from_dev),
    .bd_from_sock (bd_from_sock),
    .clean        (clean_vec)
  );

  assign trace_tap = clean_vec;
  assign hit_vec   = fault_mask & {N_PIN{fault_en}};

  for (genvar i = 0; i < N_PIN; i++) begin : g_pin
    assign nb_up[i] = clean_vec[idx_up(i, N_PIN)];
    assign nb_dn[i] = clean_vec[idx_dn(i, N_PIN)];

    fi_elem #(.OPEN_LEVEL(OPEN_LEVEL)) elem_i (
      .hit       (hit_vec[i]),
      .kind      (fault_kind),
      .clean     (clean_vec[i]),
      .ext       (ext_level[i]),
      .up        (nb_up[i]),
      .dn        (nb_dn[i]),
      .out_val   (faulty_val[i]),
      .out_drive (faulty_drive[i])
    );
  end

  assign uni_to_sock     = faulty_val[N_UNI-1:0];
  assign uni_to_sock_drv = faulty_drive[N_UNI-1:0];

  for (genvar j = 0; j < N_BIDIR; j++) begin : g_bd
    fi_bidir_route route_i (
      .dir          (bd_dir[j]),
      .from_dev     (bd_from_dev[j]),
      .from_sock    (bd_from_sock[j]),
      .faulty_val   (faulty_val[N_UNI+j]),
      .faulty_drive (faulty_drive[N_UNI+j]),
      .to_sock      (bd_to_sock[j]),
      .to_sock_drv  (bd_to_sock_drv[j]),
      .to_dev       (bd_to_dev[j]),
      .to_dev_drv   (bd_to_dev_drv[j])
    );
  end

endmodule

// File: rtl/fi_pin_bank_chk.sv
module fi_pin_bank_chk #(
  parameter int unsigned N_UNI      = 8,
  parameter int unsigned N_BIDIR    = 8,
  parameter logic        OPEN_LEVEL = 1'b0,
  localparam int unsigned N_PIN     = N_UNI + N_BIDIR
) (
  input logic               fault_en,
  input logic [2:0]         fault_kind,
  input logic [N_PIN-1:0]   fault_mask,
  input logic [N_PIN-1:0]   ext_level,
  input logic [N_UNI-1:0]   uni_from_dev,
  input logic [N_UNI-1:0]   uni_to_sock,
  input logic [N_UNI-1:0]   uni_to_sock_drv,
  input logic [N_BIDIR-1:0] bd_dir,
  input logic [N_BIDIR-1:0] bd_from_dev,
  input logic [N_BIDIR-1:0] bd_from_sock,
  input logic [N_BIDIR-1:0] bd_to_sock,
  input logic [N_BIDIR-1:0] bd_to_sock_drv,
  input logic [N_BIDIR-1:0] bd_to_dev,
  input logic [N_BIDIR-1:0] bd_to_dev_drv,
  input logic [N_PIN-1:0]   trace_tap
);

  logic hit0;
  assign hit0 = fault_en && fault_mask[0];

  always_comb begin
    // R1
    if (!fault_en) begin
      pass_through_chk: assert (uni_to_sock == uni_from_dev && &uni_to_sock_drv);
    end
    // R10
    trace_uni_chk: assert (trace_tap[N_UNI-1:0] == uni_from_dev);
    // R3
    if (hit0 && fault_kind == 3'd2) begin
      ext_level_chk: assert (uni_to_sock[0] == ext_level[0]);
    end
    // R4
    if (hit0 && fault_kind == 3'd3) begin
      invert_chk: assert (uni_to_sock[0] != uni_from_dev[0]);
    end
    // R7
    if (hit0 && fault_kind == 3'd6) begin
      open_float_chk: assert (!uni_to_sock_drv[0] && uni_to_sock[0] == OPEN_LEVEL);
    end
    for (int j = 0; j < N_BIDIR; j++) begin
      // R10
      trace_bd_chk: assert (trace_tap[N_UNI+j] == (bd_dir[j] ? bd_from_dev[j] : bd_from_sock[j]));
      // R11
      if (bd_dir[j]) begin
        idle_dev_side_chk: assert (bd_to_dev[j] == bd_from_sock[j] && !bd_to_dev_drv[j]);
      end else begin
        idle_sock_side_chk: assert (bd_to_sock[j] == bd_from_dev[j] && !bd_to_sock_drv[j]);
      end
    end
    for (int i = 0; i < N_UNI; i++) begin
      // R9
      if (!fault_mask[i]) begin
        unmasked_pass_chk: assert (uni_to_sock[i] == uni_from_dev[i] && uni_to_sock_drv[i]);
      end
    end
  end

endmodule

bind fi_pin_bank fi_pin_bank_chk #(
  .N_UNI(N_UNI), .N_BIDIR(N_BIDIR), .OPEN_LEVEL(OPEN_LEVEL)
) chk_i (.*);

// File: tb/fi_pin_bank_tb_top.sv
module fi_pin_bank_tb_top;

  localparam int unsigned NU = 5;
  localparam int unsigned NB = 6;
  localparam int unsigned NP = NU + NB;
  localparam logic       OLVL = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          fault_en;
  logic [2:0]    fault_kind;
  logic [NP-1:0] fault_mask, ext_level;
  logic [NU-1:0] uni_from_dev, uni_to_sock, uni_to_sock_drv;
  logic [NB-1:0] bd_dir, bd_from_dev, bd_from_sock;
  logic [NB-1:0] bd_to_sock, bd_to_sock_drv, bd_to_dev, bd_to_dev_drv;
  logic [NP-1:0] trace_tap;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  fi_pin_bank #(.N_UNI(NU), .N_BIDIR(NB), .OPEN_LEVEL(OLVL)) dut_i (
    .fault_en(fault_en), .fault_kind(fault_kind), .fault_mask(fault_mask),
    .ext_level(ext_level), .uni_from_dev(uni_from_dev), .uni_to_sock(uni_to_sock),
    .uni_to_sock_drv(uni_to_sock_drv), .bd_dir(bd_dir), .bd_from_dev(bd_from_dev),
    .bd_from_sock(bd_from_sock), .bd_to_sock(bd_to_sock), .bd_to_sock_drv(bd_to_sock_drv),
    .bd_to_dev(bd_to_dev), .bd_to_dev_drv(bd_to_dev_drv), .trace_tap(trace_tap)
  );

  // Bench model of the clean vector: unidirectional first, then bidirectional.
  function automatic logic [NP-1:0] m_clean();
    logic [NP-1:0] c;
    for (int i = 0; i < NU; i++) c[i] = uni_from_dev[i];
    for (int j = 0; j < NB; j++) c[NU+j] = bd_dir[j] ? bd_from_dev[j] : bd_from_sock[j];
    return c;
  endfunction

  // Expected active-side value of pin i.
  function automatic logic m_val(input int i);
    logic [NP-1:0] c;
    int nx, pv;
    c = m_clean();
    nx = (i == NP-1) ? 0 : i + 1;
    pv = (i == 0) ? NP-1 : i - 1;
    if (!(fault_en && fault_mask[i])) return c[i];
    case (fault_kind)
      3'd0: return 1'b1;
      3'd1: return 1'b0;
      3'd2: return ext_level[i];
      3'd3: return !c[i];
      3'd4: return c[i] && c[nx];
      3'd5: return c[i] && c[pv];
      3'd6: return OLVL;
      default: return c[i];
    endcase
  endfunction

  function automatic logic m_drv(input int i);
    return !(fault_en && fault_mask[i] && fault_kind == 3'd6);
  endfunction

  function automatic string kind_tag();
    if (!fault_en) return "R1";
    case (fault_kind)
      3'd0, 3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (kind %0d en %0b mask %h dir %h)",
               tag, act, exp, fault_kind, fault_en, fault_mask, bd_dir);
    end
  endtask

  task automatic check_all();
    logic [NU-1:0] eu, eud;
    logic [NB-1:0] es, esd, ed, edd;
    logic [NP-1:0] c;
    @(negedge clk);
    c = m_clean();
    for (int i = 0; i < NU; i++) begin
      eu[i] = m_val(i);
      eud[i] = m_drv(i);
    end
    for (int j = 0; j < NB; j++) begin
      if (bd_dir[j]) begin
        es[j] = m_val(NU+j); esd[j] = m_drv(NU+j);
        ed[j] = bd_from_sock[j]; edd[j] = 1'b0;
      end else begin
        ed[j] = m_val(NU+j); edd[j] = m_drv(NU+j);
        es[j] = bd_from_dev[j]; esd[j] = 1'b0;
      end
    end
    cmp("R10", 16'(trace_tap), 16'(c));
    cmp(kind_tag(), 16'(uni_to_sock), 16'(eu));
    cmp(kind_tag(), 16'({bd_to_sock & bd_dir, bd_to_dev & ~bd_dir}),
        16'({es & bd_dir, ed & ~bd_dir}));
    cmp("R11", 16'({bd_to_sock & ~bd_dir, bd_to_dev & bd_dir}),
        16'({es & ~bd_dir, ed & bd_dir}));
    cmp("R12", 16'({uni_to_sock_drv, bd_to_sock_drv, bd_to_dev_drv}), 16'({eud, esd, edd}));
    cmp("R9", 16'(uni_to_sock & ~fault_mask[NU-1:0]),
        16'(uni_from_dev & ~fault_mask[NU-1:0]));
    @(posedge clk);
  endtask

  task automatic rand_pins();
    uni_from_dev = NU'($urandom);
    bd_dir       = NB'($urandom);
    bd_from_dev  = NB'($urandom);
    bd_from_sock = NB'($urandom);
    ext_level    = NP'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f0c_a5e7));
    fault_en = 1'b0; fault_kind = 3'd0; fault_mask = '0; ext_level = '0;
    uni_from_dev = '0; bd_dir = '0; bd_from_dev = '0; bd_from_sock = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle state: everything low, no fault (R1)
    check_all();
    // R1: fault disabled with all mask bits set and every code
    for (int k = 0; k < 8; k++) begin
      fault_kind = 3'(k); fault_mask = '1; rand_pins();
      check_all();
    end
    // R5 and R6: wrap at both ends, across the group boundary
    fault_en = 1'b1; fault_mask = '1; bd_dir = '1;
    uni_from_dev = 5'b00001; bd_from_dev = 6'b100000;
    fault_kind = 3'd4; check_all();
    fault_kind = 3'd5; check_all();
    uni_from_dev = 5'b10000; bd_from_dev = 6'b000001; bd_dir = 6'b000001;
    fault_kind = 3'd4; check_all();
    fault_kind = 3'd5; check_all();
    // R7: open on both directions
    fault_kind = 3'd6; bd_dir = 6'b101010; check_all();
    // R8: reserved code passes through
    fault_kind = 3'd7; rand_pins(); check_all();
    // R4: single pin inversion, neighbours untouched (R9)
    fault_kind = 3'd3; fault_mask = NP'(1) << 2; rand_pins(); check_all();
    // R2 and R3 on mixed directions
    for (int k = 0; k < 3; k++) begin
      fault_kind = 3'(k); fault_mask = '1; rand_pins(); check_all();
    end
    // Random sweep
    for (int n = 0; n < 400; n++) begin
      fault_en   = ($urandom % 4) != 0;
      fault_kind = 3'($urandom);
      fault_mask = NP'($urandom);
      rand_pins();
      check_all();
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule